// File: doc/BRIEF.md
# Keyed Service Watchdog Counter

This block is a software watchdog. A down counter advances on a prescaled tick
enable. When it runs out, the block raises a one-cycle timeout request, which
the system can route to a reset or an interrupt controller. The counter then
restarts from a programmable reload value. Software keeps the timeout from
happening by writing a two-word key pair to a service register.

The first key is 0x556C and the second is 0xAA39. The pair counts only in that
order. A stray value written between the two keys cancels the pair. The service
register may be written at any time and always reads as zero.

A second register holds the reload value, and software can read it back. Both
registers sit on a plain register bus with address, write data, write strobe and
combinational read data. The service register is at 0x1000E by default. The
reload register is at 0x10010 by default.

Top module: `svc_wdg_top`

## Requirements
- R1: After reset the counter holds its maximum value (all ones, 255 for an 8-bit counter), the reload register reads all ones, the key matcher is disarmed and `timeout_o` is low. With a tick on every cycle, the first timeout follows the 256th tick for an 8-bit counter.
- R2: A write of 0x556C to the service address arms the matcher. Writing 0x556C again while it is armed leaves it armed.
- R3: A write of 0xAA39 to the service address while the matcher is armed loads the counter from the reload register and disarms the matcher.
- R4: A write of 0xAA39 while the matcher is disarmed does not reload the counter. A service write of any value other than the two keys disarms the matcher. Writing 0xAA39 before 0x556C (reverse order) therefore never services the watchdog.
- R5: Bus writes to any other address leave the armed state unchanged.
- R6: A read of the service address returns zero, whatever was written there. A read of the reload address returns the reload value, zero-extended.
- R7: On each cycle with `tick_en` high and no service, the counter decrements by one if it is non-zero. Without a tick it holds.
- R8: A tick while the counter is zero raises `timeout_o` for exactly the next cycle and loads the counter from the reload value. With ticks only, the timeout period is reload+1 ticks.
- R9: A service in the same cycle as a tick takes priority: the counter loads and no timeout is raised. Writing the reload register does not change the running count. It only affects later loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | ADDR_W (20) | Register bus address |
| bus_wdata | input | DATA_W (16) | Register bus write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | DATA_W (16) | Combinational read data for `bus_addr` |
| tick_en | input | 1 | Prescaled tick enable for the counter |
| timeout_o | output | 1 | One-cycle timeout request |

## Verification
Several properties are checked on every cycle by assertions:
- a first key arms the matcher;
- a non-key service write disarms it;
- writes elsewhere leave the armed state alone;
- a service loads the reload value;
- the counter decrements or holds exactly as the tick enable dictates;
- every timeout follows a tick taken at zero;
- the service address always reads zero.

Some behaviours appear only in the bench scenarios. These are the end-to-end timeout periods, including the 256-tick period after reset and a sweep of reload values. They also include the refusal of the reverse key order and of an interrupted pair, and the priority of a service over a coinciding tick.

// File: rtl/svc_wdg_pkg.sv
package svc_wdg_pkg;
  localparam int unsigned KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 16'h556C;
  localparam logic [KEY_W-1:0] KEY_SECOND = 16'hAA39;
endpackage

// File: rtl/svc_wdg_keymatch.sv
module svc_wdg_keymatch
  import svc_wdg_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_svc,
  input  logic [DATA_W-1:0] wdata,
  output logic              svc_fire
);
  logic armed_q, armed_d;
  logic is_first, is_second;

  assign is_first  = (wdata[KEY_W-1:0] == KEY_FIRST)  && (wdata[DATA_W-1:KEY_W-1] == '0 || DATA_W == KEY_W);
  assign is_second = (wdata[KEY_W-1:0] == KEY_SECOND) && (wdata[DATA_W-1:KEY_W-1] == '0 || DATA_W == KEY_W);

  always_comb begin
    armed_d = armed_q;
    if (wr_svc) begin
      armed_d = is_first;
    end
  end

  assign svc_fire = wr_svc && is_second && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  AST_ARM_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_svc && is_first) |=> armed_q); // R2
  AST_DISARM_ON_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_svc && !is_first) |=> !armed_q); // R4
  AST_ARM_KEPT_ELSEWHERE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_svc |=> $stable(armed_q)); // R5
endmodule

// File: rtl/svc_wdg_counter.sv
module svc_wdg_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             svc_fire,
  input  logic [CNT_W-1:0] reload_val,
  output logic             timeout_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             tmo_q, tmo_d;
  logic             at_zero;

  assign at_zero = (count_q == '0);

  always_comb begin
    count_d = count_q;
    tmo_d   = 1'b0;
    if (svc_fire) begin
      count_d = reload_val;
    end else if (tick_en) begin
      if (at_zero) begin
        count_d = reload_val;
        tmo_d   = 1'b1;
      end else begin
        count_d = count_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '1;
      tmo_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      tmo_q   <= tmo_d;
    end
  end

  assign timeout_o = tmo_q;

  AST_LOAD_ON_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_fire |=> (count_q == $past(reload_val))); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !svc_fire && count_q != '0) |=> (count_q == CNT_W'($past(count_q) - 1'b1))); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !svc_fire) |=> $stable(count_q)); // R7
  AST_TIMEOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> ($past(tick_en) && !$past(svc_fire) && $past(count_q) == '0)); // R8
  AST_NO_TIMEOUT_ON_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_fire |=> !timeout_o); // R9
endmodule

// File: rtl/svc_wdg_top.sv
module svc_wdg_top #(
  parameter int unsigned          ADDR_W   = 20,
  parameter int unsigned          DATA_W   = 16,
  parameter int unsigned          CNT_W    = 8,
  parameter logic [ADDR_W-1:0]    SVC_ADDR = 20'h1000E,
  parameter logic [ADDR_W-1:0]    RLD_ADDR = 20'h10010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_en,
  output logic              timeout_o
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   wr_svc, wr_rld, svc_fire;
  logic [CNT_W-1:0]       reload_q, reload_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  assign wr_svc = bus_we && (bus_addr == SVC_ADDR);
  assign wr_rld = bus_we && (bus_addr == RLD_ADDR);

  always_comb begin
    reload_d = reload_q;
    if (wr_rld) reload_d = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) reload_q <= '1;
    else            reload_q <= reload_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == RLD_ADDR) bus_rdata = DATA_W'(reload_q);
  end

  svc_wdg_keymatch #(.DATA_W(DATA_W)) u_keys (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_svc   (wr_svc),
    .wdata    (bus_wdata),
    .svc_fire (svc_fire)
  );

  svc_wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick_en    (tick_en),
    .svc_fire   (svc_fire),
    .reload_val (reload_q),
    .timeout_o  (timeout_o)
  );

  AST_SVC_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr == SVC_ADDR) |-> (bus_rdata == '0)); // R6
endmodule

// File: tb/svc_wdg_top_tb.sv
`timescale 1ns/1ps
module svc_wdg_top_tb;
  localparam int unsigned ADDR_W = 20;
  localparam int unsigned DATA_W = 16;
  localparam logic [ADDR_W-1:0] SVC = 20'h1000E;
  localparam logic [ADDR_W-1:0] RLD = 20'h10010;
  localparam logic [15:0] K1 = 16'h556C;
  localparam logic [15:0] K2 = 16'hAA39;

  logic clk, rst_n, bus_we, tick_en, timeout_o;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  int n_chk, n_fail, idx;

  svc_wdg_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .tick_en(tick_en), .timeout_o(timeout_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d, input logic tk);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick_en = tk;
    @(negedge clk);
    bus_we = 1'b0; tick_en = 1'b0; bus_addr = '0;
  endtask

  task automatic service();
    wr(SVC, K1, 1'b0);
    wr(SVC, K2, 1'b0);
  endtask

  // Ticks up to maxn times; returns index of the tick followed by a timeout, 0 if none.
  task automatic measure(input int maxn, output int found);
    found = 0;
    for (int i = 1; i <= maxn; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      if (timeout_o) begin found = i; return; end
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output int v);
    @(negedge clk); bus_addr = a; #1; v = int'(bus_rdata); bus_addr = '0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_we = 1'b0; tick_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(timeout_o == 1'b0, "R1 timeout low after reset", timeout_o, 0);
    rd(RLD, v); chk(v == 255, "R1 reload reset value", v, 255);
    rd(SVC, v); chk(v == 0, "R6 service reads zero", v, 0);
    // R1: reset count 255 -> first timeout on tick 256; R8 pulse is one cycle
    measure(300, idx); chk(idx == 256, "R1 first expiry", idx, 256);
    @(negedge clk); chk(timeout_o == 1'b0, "R8 single-cycle pulse", timeout_o, 0);

    // R6 reads
    wr(SVC, 16'hFFFF, 1'b0);
    rd(SVC, v); chk(v == 0, "R6 service reads zero after write", v, 0);
    wr(RLD, 16'd5, 1'b0);
    rd(RLD, v); chk(v == 5, "R6 reload readback", v, 5);

    // R3 / R8 service and period
    service();
    measure(20, idx); chk(idx == 6, "R3 R8 period after service", idx, 6);
    measure(20, idx); chk(idx == 6, "R8 periodic reload", idx, 6);

    // R4 reverse order
    service(); measure(3, idx);
    wr(SVC, K2, 1'b0); wr(SVC, K1, 1'b0);
    measure(20, idx); chk(idx == 3, "R4 reverse order no reload", idx, 3);
    wr(SVC, 16'h0000, 1'b0);

    // R4 interrupted pair
    service(); measure(3, idx);
    wr(SVC, K1, 1'b0); wr(SVC, 16'h1234, 1'b0); wr(SVC, K2, 1'b0);
    measure(20, idx); chk(idx == 3, "R4 stray value disarms", idx, 3);

    // R2 repeated first key
    service(); measure(3, idx);
    wr(SVC, K1, 1'b0); wr(SVC, K1, 1'b0); wr(SVC, K2, 1'b0);
    measure(20, idx); chk(idx == 6, "R2 repeated first key stays armed", idx, 6);

    // R5 other address between keys, new reload used
    wr(SVC, K1, 1'b0); wr(RLD, 16'd9, 1'b0); wr(SVC, K2, 1'b0);
    measure(20, idx); chk(idx == 10, "R5 other address keeps armed", idx, 10);

    // R9 reload write does not change running count
    service(); measure(4, idx);
    wr(RLD, 16'd2, 1'b0);
    measure(20, idx); chk(idx == 6, "R9 reload write keeps count", idx, 6);
    measure(20, idx); chk(idx == 3, "R9 new reload on next period", idx, 3);

    // R7 no tick, no change
    service(); repeat (20) @(negedge clk);
    measure(20, idx); chk(idx == 3, "R7 hold without tick", idx, 3);

    // R9 service coinciding with tick at zero
    wr(RLD, 16'd4, 1'b0); service(); measure(4, idx);
    wr(SVC, K1, 1'b0); wr(SVC, K2, 1'b1);
    chk(timeout_o == 1'b0, "R9 service beats tick", timeout_o, 0);
    measure(20, idx); chk(idx == 5, "R9 load after coincident service", idx, 5);

    // R8 sweep of reload values
    for (int r = 0; r < 8; r++) begin
      wr(RLD, 16'(r), 1'b0); service();
      measure(20, idx); chk(idx == r + 1, "R8 sweep first period", idx, r + 1);
      measure(20, idx); chk(idx == r + 1, "R8 sweep second period", idx, r + 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule